// File: doc/BRIEF.md
# Command Buffer Sequencer with Single-Level Subroutine Call

The block walks a buffer of 64-bit instructions held in a memory organised as 64-byte cachelines, which is eight quadwords per cacheline. A start pulse hands it the quadword addresses of the first instruction (head) and of the position just past the last one (tail). It fetches one quadword at a time through a read port with one cycle of latency, and it executes the instructions in address order until the fetch address equals the tail. Register-write instructions appear on a write port. No-operation words are skipped.

A call instruction names a second buffer by cacheline indices. The sequencer runs that buffer to its tail, then resumes the calling buffer at the first quadword of the cacheline after the call. The rest of the call's cacheline is padding and is never fetched. The sequencer enforces the placement rules in hardware. A call in quadword slot 6 or 7 of its cacheline, a call inside a subroutine, or an unknown instruction word stops execution and raises a sticky error.

Top module: `cmdbuf_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o, wr_en_o and mem_req_o are all 0.
- R2: A word with bits 63:56 = 0x01 is a register write. Bits 55:32 go to wr_addr_o and bits 31:0 go to wr_data_o, with a one-cycle wr_en_o pulse. Writes leave the block in buffer order.
- R3: An all-zero word is a no-operation and produces no write. Any other word whose opcode is neither 0x01 nor 0x0C is illegal: error_o is set and execution stops.
- R4: A buffer ends when the fetch address equals its tail. When the top-level buffer ends, done_o pulses for exactly one cycle and busy_o is 0 in that cycle.
- R5: A word with bits 63:56 = 0x0C is a call. Its subroutine head cacheline index starts at bit 26 and its tail cacheline index starts at bit 0, each ADDR_W-3 bits wide. The byte address is the index times 64, so the quadword address is the index times 8. The subroutine runs before any later instruction of the caller.
- R6: When the subroutine ends, execution resumes at quadword slot 0 of the cacheline after the call. The slots after the call in its own cacheline are not executed.
- R7: A call found in slot 6 or 7 (quadword address bits 2:0 equal to 6 or 7) sets error_o and stops execution. It does not enter the subroutine. Slot 5 is legal.
- R8: A call met while a subroutine is running sets error_o and stops execution. Writes already issued stay issued.
- R9: error_o remains set until the next accepted start, which clears it. A stopped run gives no done_o pulse.
- R10: start_i is ignored while busy_o is 1.
- R11: Each fetch raises mem_req_o with mem_addr_o for one cycle. The word is taken from mem_rdata_i in the following cycle.
- R12: A call whose head index equals its tail index runs nothing and returns at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| head_i | input | ADDR_W | Quadword address of the first top-level instruction |
| tail_i | input | ADDR_W | Quadword address where the top-level buffer ends |
| mem_req_o | output | 1 | Instruction fetch strobe |
| mem_addr_o | output | ADDR_W | Quadword fetch address |
| mem_rdata_i | input | 64 | Fetched instruction, one cycle after the strobe |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | WR_ADDR_W | Register write address |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | A buffer is being executed |
| done_o | output | 1 | One-cycle pulse when the top-level buffer ends |
| error_o | output | 1 | Sticky fault flag |

## Verification
The bench fills the padding slots after each call with live write instructions. A sequencer that returned to the slot right after the call would emit those writes, and the bench would see them. The slot 6 case, the nested-call case and the unknown-opcode case each expect a halt with error and no done pulse. A design that checked the slot with the wrong bits, or that allowed nesting, would run on and emit writes the bench does not expect. The bench also runs a subroutine with an empty range, to catch a design that fetches past its tail. It pulses start while busy, to catch a restart in the middle of a run.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_CALL  = 8'h0C;
  localparam int CALL_HEAD_LSB = 26;
  localparam int CALL_TAIL_LSB = 0;
  localparam int SLOT_W = 3;  // 8 quadwords per 64-byte cacheline

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} seq_state_e;
  typedef enum logic [1:0] {K_NOP, K_WRITE, K_CALL, K_BAD} instr_kind_e;
endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
#(
  parameter int CL_W      = 10,
  parameter int WR_ADDR_W = 24
) (
  input  logic [63:0]          instr_i,
  output instr_kind_e          kind_o,
  output logic [WR_ADDR_W-1:0] wr_addr_o,
  output logic [31:0]          wr_data_o,
  output logic [CL_W-1:0]      call_head_o,
  output logic [CL_W-1:0]      call_tail_o
);
  logic [7:0] opcode;

  assign opcode      = instr_i[63:56];
  assign wr_addr_o   = instr_i[32 +: WR_ADDR_W];
  assign wr_data_o   = instr_i[31:0];
  assign call_head_o = instr_i[CALL_HEAD_LSB +: CL_W];
  assign call_tail_o = instr_i[CALL_TAIL_LSB +: CL_W];

  always_comb begin
    if (instr_i == 64'd0)        kind_o = K_NOP;
    else if (opcode == OP_WRITE) kind_o = K_WRITE;
    else if (opcode == OP_CALL)  kind_o = K_CALL;
    else                         kind_o = K_BAD;
  end
endmodule

// File: rtl/cmdseq_ptr.sv
module cmdseq_ptr
  import cmdseq_pkg::*;
#(
  parameter int QW_W = 13,
  parameter int CL_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [QW_W-1:0] head_i,
  input  logic [QW_W-1:0] tail_i,
  input  logic            adv_i,
  input  logic            call_i,
  input  logic [CL_W-1:0] call_head_i,
  input  logic [CL_W-1:0] call_tail_i,
  input  logic            ret_i,
  output logic [QW_W-1:0] ptr_o,
  output logic            at_end_o,
  output logic            in_sub_o
);
  logic [QW_W-1:0] ptr_q, top_tail_q, sub_tail_q, ret_q;
  logic            in_sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      top_tail_q <= '0;
      sub_tail_q <= '0;
      ret_q      <= '0;
      in_sub_q   <= 1'b0;
    end else if (load_i) begin
      ptr_q      <= head_i;
      top_tail_q <= tail_i;
      in_sub_q   <= 1'b0;
    end else if (call_i) begin
      // resume at slot 0 of the next cacheline; rest of this one is padding
      ret_q      <= {ptr_q[QW_W-1:SLOT_W] + CL_W'(1), SLOT_W'(0)};
      ptr_q      <= {call_head_i, SLOT_W'(0)};
      sub_tail_q <= {call_tail_i, SLOT_W'(0)};
      in_sub_q   <= 1'b1;
    end else if (ret_i) begin
      ptr_q    <= ret_q;
      in_sub_q <= 1'b0;
    end else if (adv_i) begin
      ptr_q <= ptr_q + QW_W'(1);
    end
  end

  assign ptr_o    = ptr_q;
  assign in_sub_o = in_sub_q;
  assign at_end_o = (ptr_q == (in_sub_q ? sub_tail_q : top_tail_q));

  p_no_nest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |-> !in_sub_q);
  p_ret_from_sub_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |-> in_sub_q);
  p_ret_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !load_i) |=> (ptr_q[SLOT_W-1:0] == '0));
endmodule

// File: rtl/cmdbuf_seq.sv
module cmdbuf_seq
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int WR_ADDR_W = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    head_i,
  input  logic [ADDR_W-1:0]    tail_i,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic [63:0]          mem_rdata_i,
  output logic                 wr_en_o,
  output logic [WR_ADDR_W-1:0] wr_addr_o,
  output logic [31:0]          wr_data_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 error_o
);
  localparam int CL_W = ADDR_W - SLOT_W;

  seq_state_e             state_q, state_d;
  instr_kind_e            kind;
  logic [WR_ADDR_W-1:0]   dec_addr;
  logic [31:0]            dec_data;
  logic [CL_W-1:0]        call_head, call_tail;
  logic [ADDR_W-1:0]      ptr;
  logic                   at_end, in_sub;
  logic                   load, adv, call, ret, fault, finish, wr_fire;

  cmdseq_decode #(.CL_W(CL_W), .WR_ADDR_W(WR_ADDR_W)) i_decode (
    .instr_i     (mem_rdata_i),
    .kind_o      (kind),
    .wr_addr_o   (dec_addr),
    .wr_data_o   (dec_data),
    .call_head_o (call_head),
    .call_tail_o (call_tail)
  );

  cmdseq_ptr #(.QW_W(ADDR_W), .CL_W(CL_W)) i_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .head_i      (head_i),
    .tail_i      (tail_i),
    .adv_i       (adv),
    .call_i      (call),
    .call_head_i (call_head),
    .call_tail_i (call_tail),
    .ret_i       (ret),
    .ptr_o       (ptr),
    .at_end_o    (at_end),
    .in_sub_o    (in_sub)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    adv     = 1'b0;
    call    = 1'b0;
    ret     = 1'b0;
    fault   = 1'b0;
    finish  = 1'b0;
    wr_fire = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load    = 1'b1;
        state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (!at_end)     state_d = ST_WAIT;
        else if (in_sub) ret = 1'b1;
        else begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        state_d = ST_FETCH;
        unique case (kind)
          K_NOP:   adv = 1'b1;
          K_WRITE: begin
            adv     = 1'b1;
            wr_fire = 1'b1;
          end
          K_CALL: begin
            // forbidden slots 6 and 7, and no nesting
            if (in_sub || (ptr[SLOT_W-1:1] == 2'b11)) fault = 1'b1;
            else                                     call  = 1'b1;
          end
          default: fault = 1'b1;
        endcase
        if (fault) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_en_o <= wr_fire;
      done_o  <= finish;
      if (wr_fire) begin
        wr_addr_o <= dec_addr;
        wr_data_o <= dec_data;
      end
      if (load)       error_o <= 1'b0;
      else if (fault) error_o <= 1'b1;
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH) && !at_end;
  assign mem_addr_o = ptr;
  assign busy_o     = (state_q != ST_IDLE);

  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fetch_wait_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (state_q == ST_WAIT));
  p_wr_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  p_err_halts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> (!busy_o && !done_o));
  p_slot_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && kind == K_CALL && ptr[SLOT_W-1:1] == 2'b11)
      |=> (error_o && !busy_o));
endmodule

// File: tb/test_cmdbuf_seq.sv
module test_cmdbuf_seq;
  localparam int ADDR_W = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [ADDR_W-1:0] head_i = '0, tail_i = '0;
  logic        mem_req_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [63:0] mem_rdata_i;
  logic        wr_en_o;
  logic [23:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic        busy_o, done_o, error_o;

  int checks = 0, errors = 0;
  logic [63:0] mem [1024];
  logic [23:0] log_a [32];
  logic [31:0] log_d [32];
  int n_wr = 0, n_done = 0;
  logic [23:0] exp_a [32];
  logic [31:0] exp_d [32];
  int n_exp = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  cmdbuf_seq #(.ADDR_W(ADDR_W), .WR_ADDR_W(24)) i_cmdbuf_seq (.*);

  always @(posedge clk_i) begin
    mem_rdata_i <= mem[mem_addr_o[9:0]];
    if (wr_en_o) begin
      if (n_wr < 32) begin
        log_a[n_wr] <= wr_addr_o;
        log_d[n_wr] <= wr_data_o;
      end
      n_wr <= n_wr + 1;
    end
    if (done_o) n_done <= n_done + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] f_wr(input logic [23:0] a, input logic [31:0] d);
    return {8'h01, a, d};
  endfunction

  function automatic logic [63:0] f_call(input int hbyte, input int tbyte);
    logic [63:0] v;
    v = (64'(hbyte >> 6) << 26) | 64'(tbyte >> 6);
    v[63:56] = 8'h0C;
    return v;
  endfunction

  task automatic clear_all();
    for (int i = 0; i < 1024; i++) mem[i] = 64'd0;
    n_exp = 0;
  endtask

  task automatic expect_wr(input logic [23:0] a, input logic [31:0] d);
    exp_a[n_exp] = a;
    exp_d[n_exp] = d;
    n_exp++;
  endtask

  // head/tail are quadword addresses; extra_start pulses start mid-run
  task automatic run(input int head, input int tail, input bit extra_start);
    int cyc;
    @(negedge clk_i);
    n_wr = 0;
    n_done = 0;
    start_i = 1'b1;
    head_i = ADDR_W'(head);
    tail_i = ADDR_W'(tail);
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 2000) begin
      @(negedge clk_i);
      cyc++;
      if (extra_start && cyc == 3) begin
        start_i = 1'b1;
        head_i = ADDR_W'(900);
        tail_i = ADDR_W'(904);
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    chk(cyc < 2000, "R4", "watchdog run ended", cyc, 0);
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_log(input string req);
    chk(n_wr == n_exp, req, "write count", n_wr, n_exp);
    for (int i = 0; i < n_exp && i < n_wr; i++) begin
      chk(log_a[i] == exp_a[i], req, $sformatf("write %0d addr", i), log_a[i], exp_a[i]);
      chk(log_d[i] == exp_d[i], req, $sformatf("write %0d data", i), log_d[i], exp_d[i]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(!busy_o, "R1", "busy", busy_o, 0);
    chk(!done_o, "R1", "done", done_o, 0);
    chk(!error_o, "R1", "error", error_o, 0);
    chk(!wr_en_o && !mem_req_o, "R1", "wr_en/mem_req", {wr_en_o, mem_req_o}, 0);
  endtask

  // R2 R3 R4 R11: writes with a NOP between them
  task automatic t_writes();
    clear_all();
    mem[0] = f_wr(24'h000010, 32'hA0A0_0001);
    mem[1] = 64'd0;
    mem[2] = f_wr(24'h000020, 32'hA0A0_0002);
    mem[3] = f_wr(24'hFFFFFF, 32'hDEAD_BEEF);
    mem[4] = f_wr(24'h000099, 32'h0000_0BAD);  // past tail
    expect_wr(24'h000010, 32'hA0A0_0001);
    expect_wr(24'h000020, 32'hA0A0_0002);
    expect_wr(24'hFFFFFF, 32'hDEAD_BEEF);
    run(0, 4, 1'b0);
    chk_log("R2");
    chk(n_done == 1, "R4", "done pulses", n_done, 1);
    chk(!error_o, "R3", "error after NOP", error_o, 0);
  endtask

  // R5 R6: call with live writes in the padding slots
  task automatic t_call();
    clear_all();
    mem[32] = f_wr(24'h000101, 32'h1111_0001);
    mem[33] = f_call(64 * 8, 72 * 8);  // sub at qwords 64..71
    for (int i = 34; i < 40; i++) mem[i] = f_wr(24'h0000EE, 32'hBAD0_0000 + i);
    mem[40] = f_wr(24'h000103, 32'h1111_0003);
    mem[64] = f_wr(24'h000201, 32'h2222_0001);
    mem[65] = f_wr(24'h000202, 32'h2222_0002);
    expect_wr(24'h000101, 32'h1111_0001);
    expect_wr(24'h000201, 32'h2222_0001);
    expect_wr(24'h000202, 32'h2222_0002);
    expect_wr(24'h000103, 32'h1111_0003);
    run(32, 41, 1'b0);
    chk_log("R5_R6");
    chk(n_done == 1, "R5", "done pulses", n_done, 1);
    chk(!error_o, "R6", "error", error_o, 0);
  endtask

  // R12: empty subroutine; call at slot 5 is legal (R7)
  task automatic t_empty_sub();
    clear_all();
    mem[101] = f_call(96 * 8, 96 * 8);
    mem[102] = f_wr(24'h0000EE, 32'hBAD0_0102);
    mem[104] = f_wr(24'h000301, 32'h3333_0001);
    mem[96]  = f_wr(24'h0000EE, 32'hBAD0_0096);
    expect_wr(24'h000301, 32'h3333_0001);
    run(101, 105, 1'b0);
    chk_log("R12");
    chk(!error_o, "R7", "slot 5 call error", error_o, 0);
    chk(n_done == 1, "R12", "done pulses", n_done, 1);
  endtask

  // R7: call in slot 6
  task automatic t_slot_err();
    clear_all();
    mem[134] = f_call(64 * 8, 72 * 8);
    mem[135] = f_wr(24'h0000EE, 32'hBAD0_0135);
    mem[136] = f_wr(24'h0000EE, 32'hBAD0_0136);
    mem[64]  = f_wr(24'h0000EE, 32'hBAD0_0064);
    run(134, 137, 1'b0);
    chk(error_o, "R7", "error after slot 6 call", error_o, 1);
    chk(n_wr == 0, "R7", "writes", n_wr, 0);
    chk(n_done == 0, "R9", "done on fault", n_done, 0);
    chk(!busy_o, "R7", "busy", busy_o, 0);
  endtask

  // R8: nested call
  task automatic t_nest_err();
    clear_all();
    mem[200] = f_call(80 * 8, 88 * 8);
    mem[80]  = f_wr(24'h000401, 32'h4444_0001);
    mem[81]  = f_call(64 * 8, 72 * 8);
    mem[82]  = f_wr(24'h0000EE, 32'hBAD0_0082);
    mem[64]  = f_wr(24'h0000EE, 32'hBAD0_0064);
    mem[208] = f_wr(24'h0000EE, 32'hBAD0_0208);
    expect_wr(24'h000401, 32'h4444_0001);
    run(200, 209, 1'b0);
    chk_log("R8");
    chk(error_o, "R8", "error after nested call", error_o, 1);
  endtask

  // R3 illegal opcode, then R9 error cleared by next start
  task automatic t_bad_op();
    clear_all();
    mem[300] = {8'h05, 56'd7};
    mem[301] = f_wr(24'h0000EE, 32'hBAD0_0301);
    run(300, 302, 1'b0);
    chk(error_o, "R3", "error on bad opcode", error_o, 1);
    chk(n_wr == 0, "R3", "writes", n_wr, 0);
    mem[310] = f_wr(24'h000501, 32'h5555_0001);
    @(negedge clk_i);
    start_i = 1'b1;
    head_i = ADDR_W'(310);
    tail_i = ADDR_W'(311);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!error_o, "R9", "error cleared by start", error_o, 0);
    chk(busy_o, "R9", "busy after start", busy_o, 1);
    repeat (8) @(negedge clk_i);
  endtask

  // R10: start while busy ignored
  task automatic t_busy_start();
    clear_all();
    mem[900] = f_wr(24'h0000EE, 32'hBAD0_0900);
    mem[400] = f_wr(24'h000601, 32'h6666_0001);
    mem[401] = f_wr(24'h000602, 32'h6666_0002);
    mem[402] = f_wr(24'h000603, 32'h6666_0003);
    mem[403] = f_wr(24'h000604, 32'h6666_0004);
    expect_wr(24'h000601, 32'h6666_0001);
    expect_wr(24'h000602, 32'h6666_0002);
    expect_wr(24'h000603, 32'h6666_0003);
    expect_wr(24'h000604, 32'h6666_0004);
    run(400, 404, 1'b1);
    chk_log("R10");
    chk(n_done == 1, "R10", "done pulses", n_done, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 64'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_writes();
    t_call();
    t_empty_sub();
    t_slot_err();
    t_nest_err();
    t_bad_op();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule